// File: doc/BRIEF.md
# Parallel Byte Programming Port

This block is the device-side logic of a byte-wide parallel port that lets an external programmer read and program a small on-chip non-volatile array while the device is held out of normal operation. The programmer presents three active-low strobes (chip select, output enable, program pulse), a 17-bit address, a byte of write data and a flag that says the high programming voltage is present. From these the block picks one of six modes: standby, read, output off, program, program-verify or program inhibit. It drives or releases the 8-bit data bus and commits a byte on each program pulse.

The array behaves like erased cells: it comes out of reset as all ones and a program pulse can only clear bits. The stored byte becomes the AND of the old and the new value. Programming is only accepted in the upper part of the address space. A sticky flag records any program pulse given without the high voltage or while output enable is low. The array is modelled as a register file of 2^AW bytes indexed by the low address bits.

All inputs are sampled on the rising clock edge. Read data appears one clock after the inputs that select it.

Top module: `epp_port`

## Requirements
- R1: After `rst_n` is released, `data_drive` and `prog_err` are 0 and every cell reads 0xFF.
- R2: While `dev_run` is 1 the port is inactive. `data_drive` is 0 one cycle later, no program pulse changes any cell, and `prog_err` is cleared.
- R3: With `dev_run`=0, `ce_n`=0 and `oe_n`=0, one cycle later `data_drive`=1 and `data_out` holds the byte at `addr`. An address below 0x01000 reads 0xFF.
- R4: When `ce_n` or `oe_n` was 1 at the previous edge, `data_drive` is 0.
- R5: With `ce_n`=0, `oe_n`=1 and `hv_on`=1, a 1-to-0 transition of `pgm_n` (sampled 1, then 0 at the next edge) writes `data_in` at `addr` on that edge.
- R6: Each falling program pulse writes at most one byte. Holding `pgm_n` low, or changing `data_in` while it is held low, writes nothing more.
- R7: Program-verify (`ce_n`=0, `oe_n`=0, `pgm_n`=1, `hv_on`=1) drives the stored byte, exactly like a read.
- R8: Program inhibit (`ce_n`=0, `oe_n`=1, `pgm_n`=1) keeps the bus released and never writes.
- R9: Writes to addresses below 0x01000 are ignored. The legal region runs from 0x01000 to 0x1FFFF. Cells are indexed by `addr[9:0]` (default AW=10), so region addresses 0x400 apart share a cell.
- R10: A write stores old AND `data_in`, so a cell's bits only go from 1 to 0.
- R11: A falling program pulse with `ce_n`=0, `dev_run`=0 and either `hv_on`=0 or `oe_n`=0 sets `prog_err` from the next cycle on. That pulse writes nothing, and the flag stays set until `dev_run` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; the array returns to all ones |
| dev_run | input | 1 | 1 = device in normal operation, port inactive |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program pulse |
| hv_on | input | 1 | High programming voltage present |
| addr | input | 17 | Byte address |
| data_in | input | 8 | Byte to program |
| data_out | output | 8 | Byte driven toward the bus |
| data_drive | output | 1 | Bus driver enable; 0 = bus released |
| prog_err | output | 1 | Sticky illegal-program-pulse flag |

## Verification
The bench goes after a program pulse held low across several cycles while the data changes. An edge-blind design would overwrite the cell with later data. It also sends pulses into the region just below 0x01000 and checks them through the aliased cell inside the region, where a missing range check shows up as a cleared bit. It programs the same cell twice with overlapping patterns, so a plain store instead of an AND would bring a 0 bit back to 1. It checks that pulses without high voltage, or with output enable low, set the flag and leave the cell alone, and that the run-mode input both releases the bus and clears the flag.

// File: rtl/epp_pkg.sv
package epp_pkg;

  localparam int ADDR_W  = 17;
  localparam int BYTE_W  = 8;

  typedef enum logic [2:0] {
    PM_STANDBY = 3'd0,
    PM_READ    = 3'd1,
    PM_OUT_OFF = 3'd2,
    PM_PROGRAM = 3'd3,
    PM_VERIFY  = 3'd4,
    PM_INHIBIT = 3'd5
  } port_mode_e;

  // Decode of the strobe set into one of the port modes.
  function automatic port_mode_e decode_mode(input logic active, input logic ce_n,
                                             input logic oe_n, input logic pgm_n,
                                             input logic hv);
    port_mode_e m;
    if (!active || ce_n)      m = PM_STANDBY;
    else if (!oe_n)           m = (hv && pgm_n) ? PM_VERIFY : PM_READ;
    else if (pgm_n)           m = PM_INHIBIT;
    else if (hv)              m = PM_PROGRAM;
    else                      m = PM_OUT_OFF;
    return m;
  endfunction

  // Modes in which the byte is driven onto the bus.
  function automatic logic mode_drives(input port_mode_e m);
    return (m == PM_READ) || (m == PM_VERIFY);
  endfunction

  // Programmable window check: lower bound only, the top is the end of the space.
  function automatic logic in_prog_region(input logic [ADDR_W-1:0] a,
                                          input logic [ADDR_W-1:0] lo);
    return a >= lo;
  endfunction

  // Erased-cell write: a bit can only be pulled from 1 to 0.
  function automatic logic [BYTE_W-1:0] merge_program(input logic [BYTE_W-1:0] old_b,
                                                      input logic [BYTE_W-1:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/epp_mode_decode.sv
module epp_mode_decode
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_run,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       pgm_n,
  input  logic       hv_on,
  output port_mode_e mode,
  output logic       pgm_fall,
  output logic       wr_req,
  output logic       strobe_bad
);

  logic pgm_prev_q;
  logic active;

  assign active = !dev_run;

  // Previous level of the program pulse, for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_prev_q <= 1'b1;
    else        pgm_prev_q <= pgm_n;
  end

  assign pgm_fall = pgm_prev_q && !pgm_n;
  assign mode     = decode_mode(active, ce_n, oe_n, pgm_n, hv_on);

  // A legal program pulse is an edge seen while in program mode.
  assign wr_req     = pgm_fall && (mode == PM_PROGRAM);
  // An edge with the chip selected but the voltage or output enable wrong.
  assign strobe_bad = pgm_fall && active && !ce_n && (!hv_on || !oe_n);

  // R6: an edge lasts one cycle, so two requests never come back to back.
  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

endmodule

// File: rtl/epp_cell_array.sv
module epp_cell_array
  import epp_pkg::*;
#(
  parameter int AW = 10,
  parameter logic [ADDR_W-1:0] REGION_LO = 17'h01000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data_in,
  output logic [BYTE_W-1:0] rd_byte
);

  localparam int DEPTH = 1 << AW;

  logic [BYTE_W-1:0] cell_q [DEPTH];
  logic [AW-1:0]     idx;
  logic              region_ok;
  logic              cell_we;

  assign idx       = addr[AW-1:0];
  assign region_ok = in_prog_region(addr, REGION_LO);
  assign cell_we   = wr_req && region_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
    end else if (cell_we) begin
      cell_q[idx] <= merge_program(cell_q[idx], data_in);
    end
  end

  assign rd_byte = region_ok ? cell_q[idx] : '1;

  // Shadow of the last touched cell, kept for the assertions below.
  logic [AW-1:0]     last_idx_q;
  logic [BYTE_W-1:0] last_old_q;
  logic              last_we_q;
  logic              last_blocked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx_q     <= '0;
      last_old_q     <= '1;
      last_we_q      <= 1'b0;
      last_blocked_q <= 1'b0;
    end else begin
      last_idx_q     <= idx;
      last_old_q     <= cell_q[idx];
      last_we_q      <= cell_we;
      last_blocked_q <= wr_req && !region_ok;
    end
  end

  // R10: a write never raises a bit of the cell it touched.
  assert_and_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last_we_q |-> ((cell_q[last_idx_q] & ~last_old_q) == '0));

  // R9: a request below the region leaves its aliased cell untouched.
  assert_region_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_blocked_q |-> (cell_q[last_idx_q] == last_old_q));

endmodule

// File: rtl/epp_bus_out.sv
module epp_bus_out
  import epp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_run,
  input  port_mode_e        mode,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic              strobe_bad,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_drive,
  output logic              prog_err
);

  logic [BYTE_W-1:0] out_q;
  logic              drive_q;
  logic              err_q;

  // One register stage on the read path.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= mode_drives(mode);
      out_q   <= mode_drives(mode) ? rd_byte : '0;
    end
  end

  // Sticky error, cleared whenever the device is in normal operation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (dev_run)    err_q <= 1'b0;
    else if (strobe_bad) err_q <= 1'b1;
  end

  assign data_out   = out_q;
  assign data_drive = drive_q;
  assign prog_err   = err_q;

  // R11: the flag only rises after a bad program pulse.
  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_err) |-> $past(strobe_bad));

endmodule

// File: rtl/epp_port.sv
module epp_port
  import epp_pkg::*;
#(
  parameter int AW = 10,
  parameter logic [ADDR_W-1:0] REGION_LO = 17'h01000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_run,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              hv_on,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data_in,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_drive,
  output logic              prog_err
);

  port_mode_e        mode;
  logic              pgm_fall;
  logic              wr_req;
  logic              strobe_bad;
  logic [BYTE_W-1:0] rd_byte;

  epp_mode_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_run    (dev_run),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .pgm_n      (pgm_n),
    .hv_on      (hv_on),
    .mode       (mode),
    .pgm_fall   (pgm_fall),
    .wr_req     (wr_req),
    .strobe_bad (strobe_bad)
  );

  epp_cell_array #(.AW(AW), .REGION_LO(REGION_LO)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .addr    (addr),
    .data_in (data_in),
    .rd_byte (rd_byte)
  );

  epp_bus_out u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_run    (dev_run),
    .mode       (mode),
    .rd_byte    (rd_byte),
    .strobe_bad (strobe_bad),
    .data_out   (data_out),
    .data_drive (data_drive),
    .prog_err   (prog_err)
  );

  // R2: normal operation releases the bus.
  assert_run_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dev_run) |-> !data_drive);

  // R4: the bus is driven only after chip select and output enable were both low.
  assert_drive_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_drive |-> ($past(!ce_n) && $past(!oe_n)));

  // R5: a write request from the decoder needs the program-mode pins.
  assert_write_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (hv_on && oe_n && !ce_n && !dev_run && !pgm_n));

  // R8: with the pulse high no write reaches the array.
  assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_n |-> !wr_req);

endmodule

// File: tb/tb_epp_port.sv
module tb_epp_port;

  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_run = 1'b0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        pgm_n = 1'b1;
  logic        hv_on = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  data_in = '0;
  logic [7:0]  data_out;
  logic        data_drive;
  logic        prog_err;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [DEPTH];
  logic err_m = 1'b0;

  epp_port dut (
    .clk(clk), .rst_n(rst_n), .dev_run(dev_run), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .hv_on(hv_on), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_drive(data_drive), .prog_err(prog_err)
  );

  always #5 clk = ~clk;

  function automatic logic legal(input logic [16:0] a);
    return a >= 17'h01000;
  endfunction

  function automatic logic [7:0] exp_read(input logic [16:0] a);
    if (!legal(a)) return 8'hFF;
    return model[a % DEPTH];
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; hv_on = 1'b0;
  endtask

  task automatic do_read(input logic [16:0] a, input logic hv, input string req);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1; hv_on = hv;
    @(negedge clk);
    check(data_drive === 1'b1, req, {31'b0, data_drive}, 1);
    check(data_out === exp_read(a), req, {24'b0, data_out}, {24'b0, exp_read(a)});
  endtask

  // Program pulse; hold > 1 keeps the pulse low and swaps the data mid-hold.
  task automatic do_write(input logic [16:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    addr = a; data_in = d; ce_n = 1'b0; oe_n = 1'b1; hv_on = 1'b1; pgm_n = 1'b1;
    @(negedge clk);
    pgm_n = 1'b0;
    @(negedge clk);
    check(data_drive === 1'b0, "R4 program mode releases bus", {31'b0, data_drive}, 0);
    if (hold > 1) begin
      data_in = 8'h00;
      repeat (hold - 1) @(negedge clk);
    end
    pgm_n = 1'b1;
    if (legal(a) && !dev_run) model[a % DEPTH] = model[a % DEPTH] & d;
  endtask

  // kind 0: no high voltage; kind 1: output enable low.
  task automatic bad_pulse(input logic [16:0] a, input logic [7:0] d, input int kind);
    @(negedge clk);
    addr = a; data_in = d; ce_n = 1'b0; pgm_n = 1'b1;
    oe_n = (kind == 0); hv_on = (kind != 0);
    @(negedge clk);
    pgm_n = 1'b0;
    @(negedge clk);
    pgm_n = 1'b1;
    err_m = 1'b1;
    check(prog_err === 1'b1, "R11 bad pulse sets flag", {31'b0, prog_err}, 1);
  endtask

  task automatic run_pulse();
    @(negedge clk);
    dev_run = 1'b1; ce_n = 1'b1;
    @(negedge clk);
    dev_run = 1'b0;
    err_m = 1'b0;
    check(prog_err === 1'b0, "R2 run mode clears flag", {31'b0, prog_err}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(data_drive === 1'b0, "R1 reset drive", {31'b0, data_drive}, 0);
    check(prog_err === 1'b0, "R1 reset flag", {31'b0, prog_err}, 0);

    // R1: every cell erased
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      addr = 17'h01000 + 17'(i); ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      if (data_out !== 8'hFF) bad++;
    end
    check(bad == 0, "R1 all cells erased", bad, 0);

    // R3 read below the region returns all ones
    do_read(17'h00005, 1'b0, "R3 read outside region");
    // R4 float with ce or oe high
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check(data_drive === 1'b0, "R4 ce high floats", {31'b0, data_drive}, 0);
    ce_n = 1'b0; oe_n = 1'b1; pgm_n = 1'b1;
    @(negedge clk);
    check(data_drive === 1'b0, "R4 oe high floats", {31'b0, data_drive}, 0);

    // R5 and R10: program then overlap
    do_write(17'h01010, 8'hF0, 1);
    do_read(17'h01010, 1'b0, "R5 programmed byte");
    do_write(17'h01010, 8'h3C, 1);
    do_read(17'h01010, 1'b1, "R10 and-merge, R7 verify");
    do_write(17'h01010, 8'hFF, 1);
    do_read(17'h01010, 1'b1, "R10 no bit returns to one");

    // R6 held pulse with changing data
    do_write(17'h01020, 8'hA5, 5);
    do_read(17'h01020, 1'b0, "R6 one byte per pulse");

    // R8 inhibit: new data with pulse high
    @(negedge clk);
    addr = 17'h01030; data_in = 8'h00; ce_n = 1'b0; oe_n = 1'b1; hv_on = 1'b1; pgm_n = 1'b1;
    repeat (3) @(negedge clk);
    check(data_drive === 1'b0, "R8 inhibit floats", {31'b0, data_drive}, 0);
    do_read(17'h01030, 1'b0, "R8 inhibit no write");

    // R9 below region ignored; aliased cell 0x01040 shares index with 0x00040
    do_write(17'h00040, 8'h00, 1);
    do_read(17'h01040, 1'b0, "R9 write outside region ignored");
    do_write(17'h01440, 8'h0F, 1);
    do_read(17'h01040, 1'b0, "R9 alias index addr[9:0]");
    do_write(17'h1FFFF, 8'h5A, 1);
    do_read(17'h1FFFF, 1'b0, "R9 top of region");

    // R11 bad pulses write nothing
    bad_pulse(17'h01050, 8'h00, 0);
    do_read(17'h01050, 1'b0, "R11 no write without hv");
    bad_pulse(17'h01050, 8'h00, 1);
    do_read(17'h01050, 1'b0, "R11 no write with oe low");
    check(prog_err === 1'b1, "R11 flag sticky", {31'b0, prog_err}, 1);

    // R2 run mode: no drive, no write, flag cleared
    @(negedge clk);
    dev_run = 1'b1; addr = 17'h01060; data_in = 8'h00;
    ce_n = 1'b0; oe_n = 1'b0; hv_on = 1'b1; pgm_n = 1'b1;
    @(negedge clk);
    check(data_drive === 1'b0, "R2 run mode floats", {31'b0, data_drive}, 0);
    check(prog_err === 1'b0, "R2 run mode clears flag", {31'b0, prog_err}, 0);
    oe_n = 1'b1;
    @(negedge clk); pgm_n = 1'b0;
    @(negedge clk); pgm_n = 1'b1;
    @(negedge clk); dev_run = 1'b0; err_m = 1'b0;
    do_read(17'h01060, 1'b0, "R2 run mode no write");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [16:0] a;
      int r = $urandom % 3;
      int x = $urandom % 24;
      case (r)
        0: a = 17'(x);
        1: a = 17'h01000 + 17'(x);
        default: a = 17'h1FFE8 + 17'(x);
      endcase
      case ($urandom % 6)
        0, 1: do_write(a, 8'($urandom), 1 + ($urandom % 2) * 2);
        2: do_read(a, 1'b0, "R3 random read");
        3: do_read(a, 1'b1, "R7 random verify");
        4: bad_pulse(a, 8'($urandom), $urandom % 2);
        default: run_pulse();
      endcase
      go_idle();
      @(negedge clk);
      check(prog_err === err_m, "R11 random flag", {31'b0, prog_err}, {31'b0, err_m});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule